// File: doc/BRIEF.md
# Extended Capability List Walker

This block searches the extended capability list of a PCI Express configuration space for one vendor-specific capability. It is started by a one-cycle start pulse. It then reads capability headers one dword at a time through a simple synchronous read port, follows each next pointer, and stops when it finds the wanted capability, reaches the end of the list, or meets an illegal pointer. The wanted vendor-specific ID and revision are taken from input ports when the walk starts.

A capability counts as a match only when all four of these fields agree. The first header dword must carry capability ID 0x000B and version 0x1. The second dword, one dword above the header, must carry the wanted vendor ID and revision. When the walk ends, the block raises `done` together with a found flag, an error flag and the byte offset of the match. It holds these results until the next start. A hop limit stops the walk if the list loops back on itself.

Top module: `ecap_walker`

## Requirements
- R1: One cycle after an accepted start, `rd_req` is high with `rd_addr` = 0x100. While `rd_req` is high and `rd_valid` is low, `rd_req` stays high and `rd_addr` stays unchanged. A read completes in the cycle where `rd_valid` and `rd_req` are both high.
- R2: A header dword holds the capability ID in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. A next offset of 0x000 ends the walk with `done`=1, `found`=0 and `err`=0.
- R3: A non-zero next offset of 0x0FF or less ends the walk with `done`=1, `err`=1 and `found`=0. This covers both 0x0FC and 0x0FF.
- R4: A header with ID 0x000B and version 0x1 makes the engine read the dword at header+4 next. Any other ID or version causes no read at header+4, and the walk follows that header's next offset.
- R5: The dword at header+4 holds the vendor ID in bits 15:0 and the revision in bits 19:16. When both equal the wanted values, the walk ends with `found`=1, `err`=0 and `base_ofs` = the header offset. On a mismatch, the walk follows that header's next offset. `found` and `err` are never both 1, and `base_ofs` is 0 whenever `found` is 0.
- R6: At most 64 headers are read in one walk. If the 64th header has a legal non-zero next offset and does not end in a match, the walk ends with `err`=1. If the 64th header is a match, the walk ends with `found`=1.
- R7: While `done` is high, `rd_req` is low and `found`, `err` and `base_ofs` hold their values until the next start. A start during a walk is ignored. The wanted ID and revision are sampled only when a start is accepted.
- R8: During reset and after it, `done`, `found`, `err`, `rd_req` and `base_ofs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when no walk is running |
| want_vsec_id | input | 16 | Wanted vendor-specific ID |
| want_vsec_rev | input | 4 | Wanted vendor-specific revision |
| rd_req | output | 1 | Read request, held until the read completes |
| rd_addr | output | 12 | Byte offset of the dword to read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| done | output | 1 | Walk finished, held until the next start |
| found | output | 1 | The wanted capability was found |
| err | output | 1 | Illegal pointer or hop limit reached |
| base_ofs | output | 12 | Header offset of the match, 0 otherwise |

## Verification
The hop limit and the match decision can both apply to the same read completion. The 64th header of a chain can be a vendor-specific header whose second dword either matches or does not. The bench builds a chain of 63 plain headers followed by such a header, which points back to itself. With the matching ID, the walk must report found at offset 0x1FC after 65 reads. With a different ID, the same completion must end the walk with an error after 65 reads, not with one more hop.

// File: rtl/ecap_walker_pkg.sv
package ecap_walker_pkg;

    localparam int DW_W  = 32;
    localparam int OFS_W = 12;
    localparam int ID_W  = 16;
    localparam int VER_W = 4;

    localparam logic [ID_W-1:0]  VSEC_CAP_ID   = 16'h000B;
    localparam logic [VER_W-1:0] VSEC_CAP_VER  = 4'h1;
    localparam logic [OFS_W-1:0] MIN_EXT_OFS   = 12'h100;
    localparam logic [OFS_W-1:0] DWORD_STEP    = 12'h004;

    // Both dwords of a vendor-specific capability share this layout:
    // header: id / version / next; second dword: vendor id / revision / length.
    typedef struct packed {
        logic [OFS_W-1:0] upper;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } cap_dword_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_HDR,
        W_VSH,
        W_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        NX_FOLLOW,
        NX_END,
        NX_BAD
    } nxt_kind_e;

    typedef struct packed {
        logic             done;
        logic             found;
        logic             err;
        logic [OFS_W-1:0] base;
    } walk_res_t;

    function automatic nxt_kind_e classify_next(input logic [OFS_W-1:0] p);
        if (p == '0)
            return NX_END;
        else if (p < MIN_EXT_OFS)
            return NX_BAD;
        else
            return NX_FOLLOW;
    endfunction

endpackage

// File: rtl/ecap_hdr_check.sv
module ecap_hdr_check
    import ecap_walker_pkg::*;
(
    input  logic [DW_W-1:0]  dword,
    input  logic [ID_W-1:0]  want_id,
    input  logic [VER_W-1:0] want_rev,
    output logic             is_vsec_hdr,
    output logic             vsec_id_ok,
    output logic [OFS_W-1:0] next_ofs
);
    cap_dword_t view;

    always_comb begin
        view        = cap_dword_t'(dword);
        is_vsec_hdr = (view.id == VSEC_CAP_ID) && (view.ver == VSEC_CAP_VER);
        vsec_id_ok  = (view.id == want_id) && (view.ver == want_rev);
        next_ofs    = view.upper;
    end
endmodule

// File: rtl/ecap_hop_limit.sv
module ecap_hop_limit #(
    parameter int MAX_HOPS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic first,
    input  logic step,
    output logic at_limit
);
    localparam int HOP_W = $clog2(MAX_HOPS + 1);

    logic [HOP_W-1:0] hops_q;

    // hops_q = number of the header currently being visited (1-based)
    always_ff @(posedge clk) begin
        if (rst)
            hops_q <= '0;
        else if (first)
            hops_q <= HOP_W'(1);
        else if (step)
            hops_q <= hops_q + HOP_W'(1);
    end

    assign at_limit = (hops_q >= HOP_W'(MAX_HOPS));
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
    import ecap_walker_pkg::*;
#(
    parameter logic [11:0] START_OFS = 12'h100,
    parameter int          MAX_HOPS  = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] want_vsec_id,
    input  logic [3:0]  want_vsec_rev,
    output logic        rd_req,
    output logic [11:0] rd_addr,
    input  logic        rd_valid,
    input  logic [31:0] rd_data,
    output logic        done,
    output logic        found,
    output logic        err,
    output logic [11:0] base_ofs
);
    walk_st_e         st_q;
    logic [OFS_W-1:0] cur_q;
    logic [OFS_W-1:0] nxt_q;
    logic [ID_W-1:0]  want_id_q;
    logic [VER_W-1:0] want_rev_q;
    walk_res_t        res_q;

    logic             is_vsec_hdr;
    logic             vsec_id_ok;
    logic [OFS_W-1:0] dec_next;
    logic             at_limit;
    logic             launch;
    logic             take;
    logic             moving;
    logic             hop_step;
    logic             in_hdr;
    logic [OFS_W-1:0] follow_ptr;
    nxt_kind_e        kind;

    ecap_hdr_check i_dec (
        .dword       (rd_data),
        .want_id     (want_id_q),
        .want_rev    (want_rev_q),
        .is_vsec_hdr (is_vsec_hdr),
        .vsec_id_ok  (vsec_id_ok),
        .next_ofs    (dec_next)
    );

    ecap_hop_limit #(.MAX_HOPS(MAX_HOPS)) i_hops (
        .clk      (clk),
        .rst      (rst),
        .first    (launch),
        .step     (hop_step),
        .at_limit (at_limit)
    );

    always_comb begin
        in_hdr     = (st_q == W_HDR);
        rd_req     = (st_q == W_HDR) || (st_q == W_VSH);
        rd_addr    = (st_q == W_VSH) ? cur_q + DWORD_STEP : cur_q;
        launch     = start && ((st_q == W_IDLE) || (st_q == W_DONE));
        take       = rd_req && rd_valid;
        // pointer of the header being left: saved one after a vendor header
        follow_ptr = (st_q == W_VSH) ? nxt_q : dec_next;
        kind       = classify_next(follow_ptr);
        moving     = take && ((in_hdr && !is_vsec_hdr) ||
                              ((st_q == W_VSH) && !vsec_id_ok));
        hop_step   = moving && (kind == NX_FOLLOW) && !at_limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= W_IDLE;
            cur_q      <= '0;
            nxt_q      <= '0;
            want_id_q  <= '0;
            want_rev_q <= '0;
            res_q      <= '0;
        end else if (launch) begin
            st_q       <= W_HDR;
            cur_q      <= START_OFS;
            want_id_q  <= want_vsec_id;
            want_rev_q <= want_vsec_rev;
            res_q      <= '0;
        end else if (take && in_hdr && is_vsec_hdr) begin
            nxt_q <= dec_next;
            st_q  <= W_VSH;
        end else if (take && (st_q == W_VSH) && vsec_id_ok) begin
            res_q <= '{done: 1'b1, found: 1'b1, err: 1'b0, base: cur_q};
            st_q  <= W_DONE;
        end else if (moving) begin
            unique case (kind)
                NX_END: begin
                    res_q <= '{done: 1'b1, found: 1'b0, err: 1'b0, base: '0};
                    st_q  <= W_DONE;
                end
                NX_BAD: begin
                    res_q <= '{done: 1'b1, found: 1'b0, err: 1'b1, base: '0};
                    st_q  <= W_DONE;
                end
                default: begin
                    if (at_limit) begin
                        res_q <= '{done: 1'b1, found: 1'b0, err: 1'b1, base: '0};
                        st_q  <= W_DONE;
                    end else begin
                        cur_q <= follow_ptr;
                        st_q  <= W_HDR;
                    end
                end
            endcase
        end
    end

    assign done     = res_q.done;
    assign found    = res_q.found;
    assign err      = res_q.err;
    assign base_ofs = res_q.base;
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk #(
    parameter logic [11:0] START_OFS = 12'h100,
    parameter int          MAX_HOPS  = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        rd_req,
    input logic [11:0] rd_addr,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        done,
    input logic        found,
    input logic        err,
    input logic [11:0] base_ofs,
    input logic        in_hdr
);
    localparam int CNT_W = $clog2(MAX_HOPS + 2) + 1;

    logic [CNT_W-1:0] hdr_reads;
    logic             vsec_like;

    assign vsec_like = (rd_data[15:0] == 16'h000B) && (rd_data[19:16] == 4'h1);

    always_ff @(posedge clk) begin
        if (rst)
            hdr_reads <= '0;
        else if (start && !rd_req)
            hdr_reads <= '0;
        else if (rd_req && rd_valid && in_hdr)
            hdr_reads <= hdr_reads + CNT_W'(1);
    end

    p_first_read_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !rd_req) |=> (rd_req && rd_addr == START_OFS));

    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    p_list_end_r2: assert property (@(posedge clk) disable iff (rst)
        (in_hdr && rd_valid && !vsec_like && rd_data[31:20] == 12'h000)
        |=> (done && !found && !err));

    p_bad_next_r3: assert property (@(posedge clk) disable iff (rst)
        (in_hdr && rd_valid && !vsec_like && rd_data[31:20] != 12'h000 &&
         rd_data[31:20] < 12'h100) |=> (done && err && !found));

    p_second_dword_r4: assert property (@(posedge clk) disable iff (rst)
        (in_hdr && rd_valid && vsec_like)
        |=> (rd_req && rd_addr == $past(rd_addr) + 12'h004));

    p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
        found |-> (done && !err));

    p_base_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |-> (base_ofs == 12'h000));

    p_hop_bound_r6: assert property (@(posedge clk) disable iff (rst)
        hdr_reads <= CNT_W'(MAX_HOPS));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(found) && $stable(err) && $stable(base_ofs)));

    p_quiet_done_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);
endmodule

bind ecap_walker ecap_walker_chk #(
    .START_OFS (START_OFS),
    .MAX_HOPS  (MAX_HOPS)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .done     (done),
    .found    (found),
    .err      (err),
    .base_ofs (base_ofs),
    .in_hdr   (in_hdr)
);

// File: tb/test_ecap_walker.sv
`timescale 1ns/1ps
module test_ecap_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] want_vsec_id = 16'h0001;
    logic [3:0]  want_vsec_rev = 4'h0;
    logic        rd_req;
    logic [11:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        done, found, err;
    logic [11:0] base_ofs;

    always #5 clk = ~clk;

    ecap_walker i_ecap_walker (
        .clk(clk), .rst(rst), .start(start),
        .want_vsec_id(want_vsec_id), .want_vsec_rev(want_vsec_rev),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .found(found), .err(err), .base_ofs(base_ofs)
    );

    // ---------------- configuration space model ----------------
    logic [31:0] cfg [0:1023];
    logic [11:0] log_addr [0:511];
    int          rd_total = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    int          n_checks = 0;
    int          n_fail = 0;

    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rst || !rd_req) begin
            wait_cnt <= 0;
        end else if (!rd_valid) begin
            if (wait_cnt >= lat) begin
                rd_valid <= 1'b1;
                rd_data  <= cfg[rd_addr[11:2]];
                log_addr[rd_total[8:0]] <= rd_addr;
                rd_total <= rd_total + 1;
                wait_cnt <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] mk(input logic [11:0] up, input logic [3:0] v, input logic [15:0] id);
        return {up, v, id};
    endfunction

    task automatic put(input logic [11:0] ofs, input logic [31:0] val);
        cfg[ofs[11:2]] = val;
    endtask

    // Scenario builders. Header: next[31:20] ver[19:16] id[15:0];
    // second vendor dword: length[31:20] rev[19:16] vendor id[15:0].
    task automatic setup(input logic [3:0] s);
        for (int a = 0; a < 1024; a++) cfg[a] = 32'h0;
        case (s)
            4'd0: begin
                put(12'h100, mk(12'h000, 4'h1, 16'h000B));
                put(12'h104, mk(12'h02C, 4'h0, 16'h0001));
            end
            4'd1: begin
                put(12'h100, mk(12'h140, 4'h1, 16'h0001));
                put(12'h140, mk(12'h340, 4'h1, 16'h000B));
                put(12'h144, mk(12'h02C, 4'h0, 16'h0002));
                put(12'h340, mk(12'h000, 4'h1, 16'h000B));
                put(12'h344, mk(12'h02C, 4'h0, 16'h0001));
            end
            4'd2: begin
                put(12'h100, mk(12'h200, 4'h1, 16'h000B));
                put(12'h104, mk(12'h02C, 4'h2, 16'h0001));
                put(12'h200, mk(12'h000, 4'h1, 16'h000B));
                put(12'h204, mk(12'h02C, 4'h0, 16'h0001));
            end
            4'd3: begin
                put(12'h100, mk(12'h000, 4'h2, 16'h000B));
                put(12'h104, mk(12'h02C, 4'h0, 16'h0001));
            end
            4'd4: put(12'h100, mk(12'h0FC, 4'h1, 16'h0001));
            4'd5: put(12'h100, mk(12'h0FF, 4'h1, 16'h0001));
            4'd6: put(12'h100, mk(12'h100, 4'h1, 16'h0001));
            4'd7: begin
                put(12'h100, mk(12'h100, 4'h1, 16'h000B));
                put(12'h104, mk(12'h02C, 4'h0, 16'h0005));
            end
            4'd8: begin
                for (int k = 0; k < 63; k++)
                    put(12'(12'h100 + 4 * k), mk(12'(12'h104 + 4 * k), 4'h1, 16'h0001));
                put(12'h1FC, mk(12'h1FC, 4'h1, 16'h000B));
                put(12'h200, mk(12'h02C, 4'h0, 16'h0001));
            end
            default: begin
                put(12'h100, mk(12'h000, 4'h1, 16'h000C));
                put(12'h104, mk(12'h02C, 4'h0, 16'h0001));
            end
        endcase
    endtask

    function automatic string tag_of(input logic [3:0] s);
        case (s)
            4'd1:    return "R2";
            4'd3:    return "R4";
            4'd4:    return "R3";
            4'd5:    return "R3";
            4'd6:    return "R6";
            4'd7:    return "R6";
            4'd8:    return "R6";
            4'd9:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0]  scen;
        logic [15:0] vid;
        logic [3:0]  rev;
        logic [1:0]  lt;
        logic        e_found;
        logic        e_err;
        logic [11:0] e_base;
        logic [7:0]  e_reads;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 16'h0001, 4'h0, 2'd0, 1'b1, 1'b0, 12'h100, 8'd2},
        '{4'd1, 16'h0001, 4'h0, 2'd1, 1'b1, 1'b0, 12'h340, 8'd5},
        '{4'd1, 16'h0002, 4'h0, 2'd2, 1'b1, 1'b0, 12'h140, 8'd3},
        '{4'd1, 16'h0003, 4'h0, 2'd0, 1'b0, 1'b0, 12'h000, 8'd5},
        '{4'd2, 16'h0001, 4'h0, 2'd1, 1'b1, 1'b0, 12'h200, 8'd4},
        '{4'd2, 16'h0001, 4'h2, 2'd0, 1'b1, 1'b0, 12'h100, 8'd2},
        '{4'd3, 16'h0001, 4'h0, 2'd1, 1'b0, 1'b0, 12'h000, 8'd1},
        '{4'd4, 16'h0001, 4'h0, 2'd0, 1'b0, 1'b1, 12'h000, 8'd1},
        '{4'd5, 16'h0001, 4'h0, 2'd2, 1'b0, 1'b1, 12'h000, 8'd1},
        '{4'd6, 16'h0001, 4'h0, 2'd0, 1'b0, 1'b1, 12'h000, 8'd64},
        '{4'd7, 16'h0001, 4'h0, 2'd0, 1'b0, 1'b1, 12'h000, 8'd128},
        '{4'd8, 16'h0001, 4'h0, 2'd1, 1'b1, 1'b0, 12'h1FC, 8'd65},
        '{4'd8, 16'h0002, 4'h0, 2'd0, 1'b0, 1'b1, 12'h000, 8'd65},
        '{4'd9, 16'h0001, 4'h0, 2'd0, 1'b0, 1'b0, 12'h000, 8'd1}
    };

    localparam logic [11:0] S1_PATH [5] = '{12'h100, 12'h140, 12'h144, 12'h340, 12'h344};

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int snap;
        logic        h_found, h_err;
        logic [11:0] h_base;

        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "done in reset", done, 0);
        chk("R8", "rd_req in reset", rd_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8", "found after reset", found, 0);
        chk("R8", "err after reset", err, 0);
        chk("R8", "base after reset", base_ofs, 0);

        // table of scenarios
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            setup(v.scen);
            lat = int'(v.lt);
            want_vsec_id  = v.vid;
            want_vsec_rev = v.rev;
            snap = rd_total;
            pulse_start();
            chk("R1", "first address", rd_addr, 12'h100);
            chk("R1", "request after start", rd_req, 1);
            wait_done();
            chk(tag_of(v.scen), "found", found, v.e_found);
            chk(tag_of(v.scen), "err", err, v.e_err);
            chk(tag_of(v.scen), "base_ofs", base_ofs, v.e_base);
            chk(tag_of(v.scen), "read count", rd_total - snap, v.e_reads);
            if (i == 1) begin
                for (int k = 0; k < 5; k++)
                    chk("R4", "read address order", log_addr[(snap + k) & 511], S1_PATH[k]);
            end
            if (i == 6) begin
                // R4: version mismatch, header+4 never read
                chk("R4", "only header read", log_addr[snap & 511], 12'h100);
            end
        end

        // R7: results held while done, inputs changing
        h_found = found; h_err = err; h_base = base_ofs;
        want_vsec_id = 16'h0002;
        want_vsec_rev = 4'h7;
        repeat (10) @(negedge clk);
        chk("R7", "done held", done, 1);
        chk("R7", "found held", found, h_found);
        chk("R7", "err held", err, h_err);
        chk("R7", "base held", base_ofs, h_base);
        chk("R7", "no request while done", rd_req, 0);

        // R7: start mid-walk ignored, wanted values sampled at start
        setup(4'd1);
        lat = 2;
        want_vsec_id = 16'h0002;
        want_vsec_rev = 4'h0;
        snap = rd_total;
        pulse_start();
        repeat (2) @(negedge clk);
        want_vsec_id = 16'h0001;
        pulse_start();
        wait_done();
        chk("R7", "mid-walk start ignored base", base_ofs, 12'h140);
        chk("R7", "mid-walk start ignored found", found, 1);
        chk("R7", "mid-walk start read count", rd_total - snap, 3);

        // R8: reset in the middle of a looping walk
        setup(4'd6);
        lat = 0;
        pulse_start();
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8", "rd_req after mid-walk reset", rd_req, 0);
        chk("R8", "done after mid-walk reset", done, 0);
        chk("R8", "err after mid-walk reset", err, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "stays idle after reset", rd_req, 0);

        summary();
        $finish;
    end
endmodule